// File: doc/BRIEF.md
# Four-channel DMA engine

This block moves bytes between memory and up to four peripherals without the processor touching each byte. A processor writes, through byte-wide ports, a start address and a packed count/function word into each channel. It then writes a control word that enables channels and chooses how terminal count and memory-write timing behave. A peripheral raises its request line. The engine picks the highest-priority eligible request and runs one transfer for it: it acknowledges the peripheral, drives the address and the right strobe, and waits for memory to accept. It then steps the channel's address up and its count down.

A channel that finishes its last byte raises a sticky completion flag. It may also drop its own enable. A processor read of the status port collects the flags and clears them. A channel whose flag is still set is never started, even when it is re-enabled. Software must therefore collect completions before it restarts a channel.

Top module: `dma4_engine`

## Requirements
- R1: After reset, `dack`, `mem_rd` and `mem_wr` are low, `mem_addr` is zero, every channel is disabled and a status read returns 0.
- R2: Select value 2*c addresses channel c's address port and 2*c+1 its count port. Each 16-bit register takes two successive writes, low byte then high byte. One shared byte pointer serves all eight ports and flips on every write to any of them.
- R3: A write to the control port (select value 8) returns the shared byte pointer to the low byte.
- R4: A programmed count of N-1 (low 14 bits of the count register) yields exactly N transfers. The first transfer uses the programmed address, and each later one uses the address plus one, wrapping at 16 bits.
- R5: Bits 15:14 of the count register (bits 7:6 of its high byte) select the function. 1 drives `mem_wr`, 2 drives `mem_rd`, and 0 and 3 are verify cycles that drive neither strobe. The two strobes are never high together.
- R6: When several eligible channels request at once, channel 0 has the highest priority and channel 3 the lowest.
- R7: When a channel finishes the transfer that takes its count past zero, bit c of the status word sets. A status read returns the flags in bits 3:0 and clears them. A flag that sets in the cycle of the read survives it.
- R8: A channel with its status flag set is not started, whatever its enable and request. It becomes eligible again once a status read has cleared the flag.
- R9: With control bit 4 set, a channel clears its own enable bit at terminal count. With bit 4 clear, the enable stays set, so the channel resumes as soon as its flag is read.
- R10: With control bit 5 set, a write transfer holds `mem_wr` for its whole acknowledge window. With bit 5 clear, `mem_wr` is held low in the first cycle of the window.
- R11: A transfer acknowledges one channel at a time. `dack` stays high for at least two cycles and for as long as `mem_ready` is low in the second cycle. There is a cycle with `dack` low between transfers.
- R12: Control bits 3:0 enable channels 3..0. Writing 0 to the control port stops all new transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | Processor write strobe, one cycle per byte |
| cpu_rd | input | 1 | Processor read strobe; on the status port it clears the flags |
| cpu_sel | input | 4 | Port select: 2*c address, 2*c+1 count, 8 control (write) / status (read) |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rdata | output | 8 | Status flags when the status port is selected, zero otherwise |
| dreq | input | 4 | Per-channel transfer request |
| dack | output | 4 | Per-channel acknowledge, one-hot during a transfer |
| mem_addr | output | 16 | Memory address of the current transfer, zero when idle |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_ready | input | 1 | Memory accepts the current transfer |

## Verification
The bench builds the block with its default parameters: four channels, a 16-bit address and a 14-bit count. Four channels put every priority position within reach. They also make the select value 8 the shared control/status port. The 16-bit address lets short runs cross a byte boundary and wrap from FFFF to 0000. The short counts used in the vectors (0 to 4) reach terminal count within a few dozen cycles, so a single loop can cover every function code, both write timings, single-byte runs and the interaction between terminal count and flag clearing.

// File: rtl/dma4_pkg.sv
// Shared types for the four-channel DMA engine.
// Assumes the function code sits in the top two bits of a count register.
package dma4_pkg;

    typedef enum logic [1:0] {
        FN_VERIFY = 2'd0,
        FN_WRITE  = 2'd1,
        FN_READ   = 2'd2,
        FN_UNDEF  = 2'd3
    } dma_fn_e;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_SETUP = 2'd1,
        XS_ACT   = 2'd2
    } xfer_st_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/dma4_chan.sv
// One DMA channel: the address register and the count/function register.
// Both load byte-wise under an external byte pointer. On each completed
// transfer the address steps up and the count steps down.
// Assumes CNT_W + FN_W == 16 and ADDR_W == 16 (two bytes each).
module dma4_chan #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 14,
    parameter int FN_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_addr,
    input  logic              ld_cnt,
    input  logic              ld_hi,
    input  logic [7:0]        wdata,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  cnt,
    output logic [FN_W-1:0]   fn,
    output logic              tc_hit
);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [FN_W-1:0]   fn_q;

    // Register update: processor loads take precedence over transfer steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
            fn_q   <= '0;
        end else if (ld_addr) begin
            if (ld_hi) addr_q[ADDR_W-1:8] <= wdata[ADDR_W-9:0];
            else       addr_q[7:0]        <= wdata;
        end else if (ld_cnt) begin
            if (ld_hi) begin
                cnt_q[CNT_W-1:8] <= wdata[CNT_W-9:0];
                fn_q             <= wdata[7:8-FN_W];
            end else begin
                cnt_q[7:0] <= wdata;
            end
        end else if (step) begin
            addr_q <= addr_q + 1'b1;
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    // Terminal count: the completing transfer takes the count past zero.
    always_comb tc_hit = step && (cnt_q == '0);

    assign addr = addr_q;
    assign cnt  = cnt_q;
    assign fn   = fn_q;

endmodule

// File: rtl/dma4_arb.sv
// Fixed-priority arbiter: the lowest-numbered requester wins.
// Assumes the request vector is already qualified by enable and status.
module dma4_arb #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] req,
    output logic [NUM_CH-1:0] gnt,
    output logic              any
);

    // Priority pick: scan from the top so that index 0 overrides the rest.
    always_comb begin
        gnt = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) gnt = NUM_CH'(1) << i;
        end
        any = |req;
    end

endmodule

// File: rtl/dma4_xfer.sv
// Transfer sequencer. It latches a grant in IDLE, spends one SETUP cycle,
// then waits in ACT for memory to accept, and pulses a per-channel step.
// Assumes the grant input is one-hot or zero.
module dma4_xfer
    import dma4_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_any,
    input  logic [NUM_CH-1:0] gnt_in,
    input  logic              mem_ready,
    output logic [NUM_CH-1:0] gnt_q,
    output logic              in_setup,
    output logic              in_act,
    output logic [NUM_CH-1:0] step
);

    xfer_st_e st_q;

    // State and grant register: the grant is held for one whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= XS_IDLE;
            gnt_q <= '0;
        end else begin
            case (st_q)
                XS_IDLE: if (req_any) begin
                    st_q  <= XS_SETUP;
                    gnt_q <= gnt_in;
                end
                XS_SETUP: st_q <= XS_ACT;
                XS_ACT: if (mem_ready) begin
                    st_q  <= XS_IDLE;
                    gnt_q <= '0;
                end
                default: begin
                    st_q  <= XS_IDLE;
                    gnt_q <= '0;
                end
            endcase
        end
    end

    // Phase decode and completion pulse.
    always_comb begin
        in_setup = (st_q == XS_SETUP);
        in_act   = (st_q == XS_ACT);
        step     = (in_act && mem_ready) ? gnt_q : '0;
    end

endmodule

// File: rtl/dma4_engine.sv
// Four-channel byte DMA engine top. It decodes processor ports, holds the
// shared byte pointer, the control word and the sticky completion flags,
// and routes the granted channel onto the memory side.
// Assumes at most one of cpu_wr / cpu_rd per cycle and NUM_CH <= 6.
module dma4_engine
    import dma4_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 14,
    parameter int FN_W   = 2,
    localparam int SEL_W = $clog2(2 * NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [SEL_W-1:0]  cpu_sel,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic [NUM_CH-1:0] dreq,
    output logic [NUM_CH-1:0] dack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic              mem_ready
);

    localparam int TCSTOP_BIT = NUM_CH;
    localparam int EXTW_BIT   = NUM_CH + 1;
    localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(2 * NUM_CH);

    logic                  bptr_q;
    logic [NUM_CH-1:0]     en_q;
    logic [NUM_CH-1:0]     flags_q;
    logic                  tc_stop_q;
    logic                  ext_w_q;

    logic                  ctrl_wr;
    logic                  stat_rd;
    logic [NUM_CH-1:0]     ld_addr;
    logic [NUM_CH-1:0]     ld_cnt;
    logic [NUM_CH-1:0]     tc_hit;
    logic [NUM_CH-1:0]     step;
    logic [NUM_CH-1:0]     eligible;
    logic [NUM_CH-1:0]     gnt_in;
    logic [NUM_CH-1:0]     gnt_q;
    logic                  req_any;
    logic                  in_setup;
    logic                  in_act;
    logic [ADDR_W-1:0]     ch_addr [NUM_CH];
    logic [CNT_W-1:0]      ch_cnt  [NUM_CH];
    logic [FN_W-1:0]       ch_fn   [NUM_CH];
    logic [ADDR_W-1:0]     cur_addr;
    logic [FN_W-1:0]       cur_fn;

    // Port decode: per-channel load strobes plus control and status access.
    always_comb begin
        ctrl_wr = cpu_wr && (cpu_sel == SEL_CTRL);
        stat_rd = cpu_rd && (cpu_sel == SEL_CTRL);
        for (int i = 0; i < NUM_CH; i++) begin
            ld_addr[i] = cpu_wr && (cpu_sel[SEL_W-1:1] == (SEL_W-1)'(i)) && !cpu_sel[0];
            ld_cnt[i]  = cpu_wr && (cpu_sel[SEL_W-1:1] == (SEL_W-1)'(i)) &&  cpu_sel[0];
        end
    end

    // Shared byte pointer: flips per register byte, cleared by control writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                      bptr_q <= 1'b0;
        else if (ctrl_wr)                bptr_q <= 1'b0;
        else if (|(ld_addr | ld_cnt))    bptr_q <= ~bptr_q;
    end

    // Control word: enables and options; terminal-count stop overrides a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= '0;
            tc_stop_q <= 1'b0;
            ext_w_q   <= 1'b0;
        end else begin
            en_q <= (ctrl_wr ? cpu_wdata[NUM_CH-1:0] : en_q)
                    & ~(tc_stop_q ? tc_hit : '0);
            if (ctrl_wr) begin
                tc_stop_q <= cpu_wdata[TCSTOP_BIT];
                ext_w_q   <= cpu_wdata[EXTW_BIT];
            end
        end
    end

    // Completion flags: read-to-clear, but a new completion always lands.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (stat_rd ? '0 : flags_q) | tc_hit;
    end

    // Status read path.
    always_comb begin
        cpu_rdata = '0;
        if (cpu_sel == SEL_CTRL) cpu_rdata[NUM_CH-1:0] = flags_q;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dma4_chan #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W),
            .FN_W   (FN_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld_addr (ld_addr[g]),
            .ld_cnt  (ld_cnt[g]),
            .ld_hi   (bptr_q),
            .wdata   (cpu_wdata),
            .step    (step[g]),
            .addr    (ch_addr[g]),
            .cnt     (ch_cnt[g]),
            .fn      (ch_fn[g]),
            .tc_hit  (tc_hit[g])
        );
    end

    // Eligibility: enabled, requesting and not holding an uncollected flag.
    always_comb eligible = en_q & dreq & ~flags_q;

    dma4_arb #(.NUM_CH(NUM_CH)) u_arb (
        .req (eligible),
        .gnt (gnt_in),
        .any (req_any)
    );

    dma4_xfer #(.NUM_CH(NUM_CH)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_any   (req_any),
        .gnt_in    (gnt_in),
        .mem_ready (mem_ready),
        .gnt_q     (gnt_q),
        .in_setup  (in_setup),
        .in_act    (in_act),
        .step      (step)
    );

    // Granted-channel mux onto the memory side.
    always_comb begin
        cur_addr = '0;
        cur_fn   = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (gnt_q[i]) begin
                cur_addr = cur_addr | ch_addr[i];
                cur_fn   = cur_fn | ch_fn[i];
            end
        end
    end

    // Memory strobes: read spans the window, write waits a cycle unless extended.
    always_comb begin
        dack     = gnt_q;
        mem_addr = cur_addr;
        mem_rd   = (in_setup || in_act) && (cur_fn == FN_READ);
        mem_wr   = (cur_fn == FN_WRITE) && (in_act || (in_setup && ext_w_q));
    end

endmodule

// File: rtl/dma4_engine_chk.sv
// Assertion checker for dma4_engine, attached with bind below.
// Assumes it observes the engine's ports and a few of its registers.
module dma4_engine_chk #(
    parameter int NUM_CH = 4,
    parameter int FN_W   = 2,
    localparam int SEL_W = $clog2(2 * NUM_CH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr,
    input logic [SEL_W-1:0]  cpu_sel,
    input logic [NUM_CH-1:0] dreq,
    input logic [NUM_CH-1:0] dack,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_ready,
    input logic [NUM_CH-1:0] en_q,
    input logic [NUM_CH-1:0] flags_q,
    input logic [NUM_CH-1:0] tc_hit,
    input logic              tc_stop_q,
    input logic              bptr_q,
    input logic [FN_W-1:0]   cur_fn
);

    a_r11_dack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));

    a_r11_dack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (dack != '0 && !mem_ready) |=> (dack == $past(dack)));

    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r5_verify_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (dack != '0 && (cur_fn == 2'd0 || cur_fn == 2'd3)) |-> (!mem_rd && !mem_wr));

    a_r8_start_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (dack != '0 && $past(dack) == '0) |->
            (($past(en_q & dreq & ~flags_q) & dack) != '0));

    a_r3_bptr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_sel == SEL_W'(2 * NUM_CH)) |=> !bptr_q);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_pc
        a_r7_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
            tc_hit[g] |=> flags_q[g]);

        a_r9_tcstop_disables: assert property (@(posedge clk) disable iff (!rst_n)
            (tc_hit[g] && tc_stop_q) |=> !en_q[g]);
    end

endmodule

bind dma4_engine dma4_engine_chk #(
    .NUM_CH (NUM_CH),
    .FN_W   (FN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_wr    (cpu_wr),
    .cpu_sel   (cpu_sel),
    .dreq      (dreq),
    .dack      (dack),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_ready (mem_ready),
    .en_q      (en_q),
    .flags_q   (flags_q),
    .tc_hit    (tc_hit),
    .tc_stop_q (tc_stop_q),
    .bptr_q    (bptr_q),
    .cur_fn    (cur_fn)
);

// File: tb/dma4_engine_tb.sv
// Self-checking bench for dma4_engine: a vector loop, then directed tests.
module dma4_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [3:0]  cpu_sel = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic [3:0]  dreq = '0;
    logic [3:0]  dack;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic        mem_ready = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dma4_engine u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .cpu_sel   (cpu_sel),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .dreq      (dreq),
        .dack      (dack),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_ready (mem_ready)
    );

    // Port monitor: counts acknowledge windows and strobe cycles per channel.
    logic [3:0]  prev_dack = '0;
    int          rises  [4];
    int          rd_cyc [4];
    int          wr_cyc [4];
    logic [15:0] last_addr [4];
    logic [11:0] order = '0;
    bit          mon_clr = 0;

    always @(negedge clk) begin
        if (mon_clr) begin
            for (int i = 0; i < 4; i++) begin
                rises[i] = 0; rd_cyc[i] = 0; wr_cyc[i] = 0; last_addr[i] = '0;
            end
            order = '0;
        end else begin
            for (int i = 0; i < 4; i++) begin
                if (dack[i] && !prev_dack[i]) begin
                    rises[i]++;
                    last_addr[i] = mem_addr;
                    order = {order[9:0], 2'(i)};
                end
                if (dack[i] && mem_rd) rd_cyc[i]++;
                if (dack[i] && mem_wr) wr_cyc[i]++;
            end
        end
        prev_dack = dack;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_mon();
        @(posedge clk); mon_clr = 1;
        @(posedge clk); mon_clr = 0;
        @(negedge clk);
    endtask

    task automatic cpu_write(input logic [3:0] sel, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_sel = sel; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [3:0] sel, output logic [7:0] d);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_sel = sel;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic prog(input int ch, input logic [15:0] a, input logic [13:0] c,
                        input logic [1:0] fn);
        cpu_write(4'(2 * ch), a[7:0]);
        cpu_write(4'(2 * ch), a[15:8]);
        cpu_write(4'(2 * ch + 1), c[7:0]);
        cpu_write(4'(2 * ch + 1), {fn, c[13:8]});
    endtask

    // Vector: {channel, function, extended write, start address, count-1}.
    localparam int NVEC = 5;
    localparam logic [34:0] VECS [NVEC] = '{
        {2'd0, 2'd1, 1'b0, 16'h1000, 14'd4},
        {2'd1, 2'd2, 1'b0, 16'h20FE, 14'd3},
        {2'd2, 2'd0, 1'b0, 16'hFFFE, 14'd2},
        {2'd3, 2'd1, 1'b1, 16'h0400, 14'd0},
        {2'd1, 2'd3, 1'b0, 16'h0010, 14'd1}
    };

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int snap;
        tick(4);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        chk("R1 dack", int'(dack), 0);
        chk("R1 mem_rd", int'(mem_rd), 0);
        chk("R1 mem_wr", int'(mem_wr), 0);
        chk("R1 mem_addr", int'(mem_addr), 0);
        cpu_read(4'd8, rd);
        chk("R1 status", int'(rd), 0);

        // Vector loop: R2 R4 R5 R7 R9 R10
        for (int v = 0; v < NVEC; v++) begin
            int ch, n, fn, ext;
            logic [15:0] a;
            ch  = int'(VECS[v][34:33]);
            fn  = int'(VECS[v][32:31]);
            ext = int'(VECS[v][30]);
            a   = VECS[v][29:14];
            n   = int'(VECS[v][13:0]) + 1;
            cpu_write(4'd8, 8'h00);
            prog(ch, a, VECS[v][13:0], 2'(fn));
            clr_mon();
            cpu_write(4'd8, 8'((1 << ch) | 8'h10 | (ext << 5)));
            dreq[ch] = 1'b1;
            tick(3 * n + 10);
            dreq[ch] = 1'b0;
            tick(2);
            chk("R4 transfer count", rises[ch], n);
            chk("R2 R4 last address", int'(last_addr[ch]), int'(16'(a + 16'(n - 1))));
            chk("R5 read strobe cycles", rd_cyc[ch], (fn == 2) ? 2 * n : 0);
            chk("R5 R10 write strobe cycles", wr_cyc[ch],
                (fn == 1) ? (ext != 0 ? 2 * n : n) : 0);
            cpu_read(4'd8, rd);
            chk("R7 status flag", int'(rd), 1 << ch);
            dreq[ch] = 1'b1;
            tick(12);
            dreq[ch] = 1'b0;
            tick(2);
            chk("R9 stays disabled after tc", rises[ch], n);
        end

        // R3: control write resets the shared byte pointer
        cpu_write(4'd8, 8'h00);
        cpu_write(4'd0, 8'hAA);
        cpu_write(4'd8, 8'h00);
        prog(0, 16'h1234, 14'd0, 2'd0);
        clr_mon();
        cpu_write(4'd8, 8'h11);
        dreq[0] = 1'b1;
        tick(12);
        dreq[0] = 1'b0;
        tick(2);
        chk("R3 single transfer", rises[0], 1);
        chk("R3 address after pointer reset", int'(last_addr[0]), 16'h1234);
        cpu_read(4'd8, rd);
        chk("R7 status ch0", int'(rd), 1);

        // R6: channel 0 beats channel 3
        cpu_write(4'd8, 8'h00);
        prog(0, 16'h0100, 14'd2, 2'd2);
        prog(3, 16'h0300, 14'd2, 2'd2);
        clr_mon();
        cpu_write(4'd8, 8'h19);
        dreq = 4'b1001;
        tick(30);
        dreq = '0;
        tick(2);
        chk("R6 grant order", int'(order), 12'h03F);
        cpu_read(4'd8, rd);
        chk("R7 status both", int'(rd), 8'h09);
        cpu_read(4'd8, rd);
        chk("R7 status cleared by read", int'(rd), 0);

        // R8/R9: without tc stop, flag blocks until read, then resumes
        cpu_write(4'd8, 8'h00);
        prog(2, 16'h0300, 14'd1, 2'd2);
        clr_mon();
        cpu_write(4'd8, 8'h04);
        dreq[2] = 1'b1;
        tick(20);
        chk("R8 blocked while flag set", rises[2], 2);
        cpu_read(4'd8, rd);
        chk("R7 status ch2", int'(rd), 8'h04);
        tick(10);
        dreq[2] = 1'b0;
        tick(3);
        chk("R9 resumes after read", int'(rises[2] > 2), 1);

        // R8 with tc stop: re-enable alone does not restart
        cpu_write(4'd8, 8'h00);
        prog(1, 16'h0500, 14'd0, 2'd1);
        clr_mon();
        cpu_write(4'd8, 8'h12);
        dreq[1] = 1'b1;
        tick(12);
        chk("R4 single run", rises[1], 1);
        cpu_write(4'd8, 8'h00);
        prog(1, 16'h0600, 14'd0, 2'd1);
        cpu_write(4'd8, 8'h12);
        tick(15);
        chk("R8 re-enable blocked", rises[1], 1);
        cpu_read(4'd8, rd);
        chk("R7 status ch1", int'(rd), 8'h02);
        tick(10);
        dreq[1] = 1'b0;
        chk("R8 starts after read", rises[1], 2);
        chk("R8 new address", int'(last_addr[1]), 16'h0600);
        cpu_read(4'd8, rd);

        // R12: writing 0 stops all new transfers
        cpu_write(4'd8, 8'h00);
        prog(2, 16'h0700, 14'd100, 2'd1);
        clr_mon();
        cpu_write(4'd8, 8'h14);
        dreq[2] = 1'b1;
        tick(10);
        cpu_write(4'd8, 8'h00);
        tick(4);
        snap = rises[2];
        tick(20);
        chk("R12 no transfers after disable", rises[2], snap);
        chk("R12 dack idle", int'(dack), 0);
        dreq[2] = 1'b0;

        // R11: acknowledge held while memory stalls
        mem_ready = 1'b0;
        prog(0, 16'h0800, 14'd0, 2'd1);
        clr_mon();
        cpu_write(4'd8, 8'h11);
        dreq[0] = 1'b1;
        tick(10);
        chk("R11 dack held in stall", int'(dack), 1);
        chk("R5 write strobe held", int'(mem_wr), 1);
        chk("R11 address held", int'(mem_addr), 16'h0800);
        mem_ready = 1'b1;
        tick(5);
        dreq[0] = 1'b0;
        chk("R11 one transfer", rises[0], 1);
        chk("R11 dack released", int'(dack), 0);
        cpu_read(4'd8, rd);
        chk("R7 status after stall", int'(rd), 1);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule